// File: doc/BRIEF.md
# Four-Channel Counter/Timer

This block holds four independent 8-bit down-counting channels behind a single host write/read port. The host picks a channel with the low two bits of the address. It configures the channel with a control word and then starts it by writing a time constant. Each channel runs in one of two roles. As an event counter, it counts rising edges on its own external trigger line. As a timer, it counts system clocks through a divide-by-16 or divide-by-256 prescaler.

When a running channel counts down to zero, it reloads its time constant and keeps going. It also emits a one-clock zero-count pulse and, if enabled, latches an interrupt request. The interrupt request stays asserted until the host reads that channel. What a read returns depends on the role. An event counter returns its live count. A timer returns its remaining count while running and 0 when it has not been started.

Control word (written while no time constant is pending): bit 0 = 1 marks a control word, bit 1 = soft reset, bit 2 = time constant follows, bit 5 = prescaler select (1 = 256, 0 = 16), bit 6 = role (1 = event counter, 0 = timer), bit 7 = interrupt enable. Bits 3 and 4 are unused.

Top module: `ctc4_top`

## Requirements
- R1: The channel is selected by addr[1:0] only; address bits above bit 1 have no effect, so addresses 5 and 0x81 both reach channel 1.
- R2: A write with wdata bit 0 = 1, made while no time constant is pending, is a control word: bit 7 enables interrupts, bit 6 = 1 selects counter role, bit 5 = 1 selects prescale 256 (else 16), bit 2 = time constant follows, bit 1 = soft reset.
- R3: After a control word with bit 2 set, the next write to that channel is taken as the time constant. It loads the count, restarts the prescaler and starts the channel.
- R4: In counter role, the count drops by one for each rising edge of that channel's trig line, and a read returns the count directly.
- R5: In timer role, the count drops by one every 16 (or 256) clocks. The first decrement comes 16 (or 256) clocks after the time-constant write edge, so a constant N gives a zero pulse 16·N (or 256·N) clocks after the load.
- R6: In timer role, a read returns the count of a running channel and 0 for a channel that was never started or was soft-reset.
- R7: A decrement that would reach zero instead reloads the time constant and drives zc for exactly one clock, starting the cycle after that edge.
- R8: A time constant of 0 gives 256 counts before the zero pulse.
- R9: With interrupts enabled, the zero event sets irq in the same cycle as zc. irq stays high until a read of that channel and then drops. With interrupts disabled, irq stays low.
- R10: A control word with bit 1 set stops the channel until a new time constant is written. A stopped counter-role channel holds its count on further trigger edges.
- R11: A write with bit 0 = 0 while no time constant is pending is ignored.
- R12: After reset, every channel reads 0, and zc and irq are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (clears the selected channel's irq) |
| addr | input | 8 | Host address, low two bits select the channel |
| wdata | input | 8 | Control word or time constant |
| rdata | output | 8 | Read value of the selected channel (combinational) |
| trig | input | 4 | Per-channel external trigger, asynchronous |
| zc | output | 4 | Per-channel one-clock zero-count pulse |
| irq | output | 4 | Per-channel latched interrupt request |

## Verification
The bench measures the exact clock distance from a time-constant load to the zero pulse for both prescale settings and for a constant of 0. An off-by-one prescaler, a wrong divider or a missing 256 wrap would show up as a different cycle count. It reads the count straight after a zero event to catch a channel that stops at zero or fails to reload. It also counts zc high cycles, so a pulse that is stretched or missing is caught. Further checks cover address aliasing, an ignored non-control write that would otherwise soft-reset a running channel, and a soft-reset counter that keeps counting edges. They also cover irq that clears without a read or sets while disabled.

// File: rtl/ctc4_pkg.sv
package ctc4_pkg;
  // Control-word bit positions
  localparam int CW_CTRL = 0;
  localparam int CW_SRST = 1;
  localparam int CW_TCF  = 2;
  localparam int CW_PRE  = 5;
  localparam int CW_ROLE = 6;
  localparam int CW_IEN  = 7;

  typedef struct packed {
    logic ien;
    logic cnt_role;
    logic pre_hi;
  } ch_mode_t;
endpackage

// File: rtl/ctc4_trig_sync.sv
module ctc4_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = trig_in;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], trig_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ctc4_prescaler.sv
module ctc4_prescaler #(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic sel_hi,
  output logic tick
);
  localparam int PW = $clog2(DIV_HI);
  localparam logic [PW-1:0] LIM_LO = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] LIM_HI = PW'(DIV_HI - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [PW-1:0] limit;

  always_comb begin
    limit = sel_hi ? LIM_HI : LIM_LO;
    tick  = en && (pre_q == limit);
    pre_d = pre_q;
    if (restart)   pre_d = '0;
    else if (tick) pre_d = '0;
    else if (en)   pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/ctc4_channel.sv
module ctc4_channel
  import ctc4_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_LO      = 16,
  parameter int DIV_HI      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              trig,
  output logic [DATA_W-1:0] rd_val,
  output logic              zc,
  output logic              irq,
  output logic              running
);
  ch_mode_t          mode_q, mode_d;
  logic              tcf_q, tcf_d;
  logic              run_q, run_d;
  logic [DATA_W-1:0] tc_q, tc_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              zc_q, zc_d;
  logic              irq_q, irq_d;

  logic is_ctrl, is_tc, tick, hit, trig_rise, pre_tick;

  ctc4_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig),
    .rise    (trig_rise)
  );

  ctc4_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (run_q && !mode_q.cnt_role),
    .restart (is_tc),
    .sel_hi  (mode_q.pre_hi),
    .tick    (pre_tick)
  );

  always_comb begin
    is_ctrl = wr_stb && !tcf_q && wdata[CW_CTRL];
    is_tc   = wr_stb && tcf_q;
    tick    = run_q && (mode_q.cnt_role ? trig_rise : pre_tick);
    hit     = tick && (cnt_q == DATA_W'(1)) && !is_tc;

    mode_d = mode_q;
    tcf_d  = tcf_q;
    run_d  = run_q;
    tc_d   = tc_q;
    cnt_d  = cnt_q;

    if (is_ctrl) begin
      mode_d.ien      = wdata[CW_IEN];
      mode_d.cnt_role = wdata[CW_ROLE];
      mode_d.pre_hi   = wdata[CW_PRE];
      tcf_d           = wdata[CW_TCF];
      if (wdata[CW_SRST]) run_d = 1'b0;
    end

    if (is_tc) begin
      tcf_d = 1'b0;
      run_d = 1'b1;
      tc_d  = wdata;
      cnt_d = wdata;
    end else if (hit) begin
      cnt_d = tc_q;
    end else if (tick) begin
      cnt_d = cnt_q - 1'b1;
    end

    zc_d = hit;
    if (hit && mode_q.ien) irq_d = 1'b1;
    else if (rd_stb)       irq_d = 1'b0;
    else                   irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tcf_q  <= 1'b0;
      run_q  <= 1'b0;
      tc_q   <= '0;
      cnt_q  <= '0;
      zc_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      tcf_q  <= tcf_d;
      run_q  <= run_d;
      tc_q   <= tc_d;
      cnt_q  <= cnt_d;
      zc_q   <= zc_d;
      irq_q  <= irq_d;
    end
  end

  // Counter role shows the live count; an idle timer reads zero
  assign rd_val  = (mode_q.cnt_role || run_q) ? cnt_q : '0;
  assign zc      = zc_q;
  assign irq     = irq_q;
  assign running = run_q;
endmodule

// File: rtl/ctc4_top.sv
module ctc4_top #(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int DIV_LO      = 16,
  parameter int DIV_HI      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_CH-1:0] trig,
  output logic [NUM_CH-1:0] zc,
  output logic [NUM_CH-1:0] irq
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic [SEL_W-1:0]  ch_sel;
  logic [DATA_W-1:0] rd_vals [NUM_CH];
  logic [NUM_CH-1:0] run_vec;

  assign ch_sel = addr[SEL_W-1:0];

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ctc4_channel #(
        .DATA_W      (DATA_W),
        .DIV_LO      (DIV_LO),
        .DIV_HI      (DIV_HI),
        .SYNC_STAGES (SYNC_STAGES)
      ) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_en && (ch_sel == SEL_W'(i))),
        .rd_stb  (rd_en && (ch_sel == SEL_W'(i))),
        .wdata   (wdata),
        .trig    (trig[i]),
        .rd_val  (rd_vals[i]),
        .zc      (zc[i]),
        .irq     (irq[i]),
        .running (run_vec[i])
      );
    end
  endgenerate

  assign rdata = rd_vals[ch_sel];
endmodule

// File: rtl/ctc4_checker.sv
module ctc4_checker #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0] zc,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] run_vec
);
  localparam int SEL_W = $clog2(NUM_CH);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      assert_zc_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zc[i] |=> !zc[i]);

      assert_irq_with_zc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[i]) |-> zc[i]);

      assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[i] && !(rd_en && addr[SEL_W-1:0] == SEL_W'(i))) |=> irq[i]);

      assert_stopped_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_vec[i] && !zc[i]) |=> !zc[i]);
    end
  endgenerate
endmodule

bind ctc4_top ctc4_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .addr    (addr),
  .zc      (zc),
  .irq     (irq),
  .run_vec (run_vec)
);

// File: tb/ctc4_top_tb.sv
module ctc4_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [7:0] addr, wdata;
  logic [7:0] rdata;
  logic [3:0] trig;
  logic [3:0] zc, irq;

  int n_chk = 0;
  int n_fail = 0;
  int zc_hits [4] = '{0, 0, 0, 0};

  typedef struct { logic [7:0] exp; string req; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  ctc4_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trig(trig), .zc(zc), .irq(irq)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 4; c++) zc_hits[c] += int'(zc[c]);
      if (rd_en) begin
        exp_t it;
        if (sb_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard: read with no expectation, actual %0d expected none", rdata);
        end else begin
          it = sb_q.pop_front();
          n_chk++;
          if (rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s: rdata actual %0d expected %0d", it.req, rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    exp_t it;
    @(posedge clk); #1;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int c);
    @(posedge clk); #1; trig[c] = 1'b1;
    repeat (3) @(posedge clk);
    #1; trig[c] = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic wait_zc(input int c, output int n);
    n = 0;
    for (int k = 0; k < 6000; k++) begin
      @(posedge clk); #1;
      n++;
      if (zc[c]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int n, h;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; trig = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12: reset state
    for (int c = 0; c < 4; c++) rd(8'(c), 8'd0, "R12 reset read");
    chk(zc == 4'b0, "R12 zc after reset", zc, 0);
    chk(irq == 4'b0, "R12 irq after reset", irq, 0);

    // R2 R3 R5 R6 R7 R9: ch0 timer /16, irq on, tc = 3
    wr(8'h00, 8'h85);
    rd(8'h00, 8'd0, "R6 idle timer reads 0");
    wr(8'h00, 8'd3);
    h = zc_hits[0];
    wait_zc(0, n);
    chk(n == 48, "R5 timer /16 period", n, 48);
    chk(irq[0] == 1'b1, "R9 irq set with zc", irq[0], 1);
    repeat (5) @(posedge clk);
    #1;
    chk(zc_hits[0] - h == 1, "R7 zc one cycle", zc_hits[0] - h, 1);
    chk(irq[0] == 1'b1, "R9 irq held until read", irq[0], 1);
    rd(8'h00, 8'd3, "R7 reload after zero");
    chk(irq[0] == 1'b0, "R9 irq cleared by read", irq[0], 0);
    repeat (10) @(posedge clk);
    #1;
    rd(8'h00, 8'd2, "R6 running timer read");

    // R1 R5 R9: ch1 via aliased address, /256, irq off, tc = 2
    wr(8'h05, 8'h25);
    wr(8'h05, 8'd2);
    wait_zc(1, n);
    chk(n == 512, "R5 timer /256 period", n, 512);
    rd(8'h81, 8'd2, "R1 aliased read ch1");
    chk(irq[1] == 1'b0, "R9 irq stays low when disabled", irq[1], 0);

    // R4 R7: ch2 counter role, tc = 5
    wr(8'h02, 8'h45);
    wr(8'h02, 8'd5);
    rd(8'h02, 8'd5, "R4 counter initial");
    for (int k = 0; k < 3; k++) pulse(2);
    rd(8'h02, 8'd2, "R4 counter after 3 edges");
    h = zc_hits[2];
    for (int k = 0; k < 2; k++) pulse(2);
    chk(zc_hits[2] - h == 1, "R7 counter zero pulse", zc_hits[2] - h, 1);
    rd(8'h02, 8'd5, "R7 counter reload");

    // R10: soft reset freezes counter
    pulse(2);
    wr(8'h02, 8'h43);
    for (int k = 0; k < 2; k++) pulse(2);
    rd(8'h02, 8'd4, "R10 stopped counter holds");
    wr(8'h02, 8'h45);
    wr(8'h02, 8'd4);
    pulse(2);
    rd(8'h02, 8'd3, "R10 restart after new tc");

    // R11: non-control write ignored on running ch3
    wr(8'h03, 8'h05);
    wr(8'h03, 8'd10);
    wr(8'h03, 8'h02);
    rd(8'h03, 8'd10, "R11 non-control write ignored");

    // R8: tc = 0 gives 256 counts
    wr(8'h03, 8'h07);
    wr(8'h03, 8'd0);
    wait_zc(3, n);
    chk(n == 4096, "R8 tc zero is 256 counts", n, 4096);

    repeat (4) @(posedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    report();
  end
endmodule